// File: doc/BRIEF.md
# Strided Memory-Mapped Disk Task-File Bridge

This bridge sits between a simple memory-mapped host bus and the register side of a parallel disk drive controller. A 4 KB address window holds one drive register every 16 bytes. Byte accesses reach the seven command-block registers and the device-control / alternate-status register. The control register answers at two separate slots. Halfword and word accesses reach only the data port at slot 0. Data-port values are byte-reversed in both directions, so a big-endian host sees drive data in its natural order.

Each host access lasts one cycle. Register-side strobes are decoded combinationally in that cycle. A read's result is registered and shows on the host side one cycle after the read strobe, together with a one-cycle valid pulse. Accesses that land on no register return all ones at the access width, and writes to them produce no register-side strobe.

Top module: `ide_win_bridge`

## Requirements
- R1: The register slot is address bits [11:4]; bits [3:0] have no effect on routing.
- R2: A byte access at slots 1 to 7 pulses the command-block read or write strobe in the same cycle, with `dev_reg_idx` equal to the slot number.
- R3: A byte access at slot 8 or slot 22 pulses `dev_ctl_wr` on a write and `dev_alt_rd` on a read, in the same cycle.
- R4: A halfword (size code 1) or word (size code 2) access at slot 0 pulses the data-port strobe, with `dev_dat_wide` = 1 for word and 0 for halfword.
- R5: Data-port write data is byte-reversed. A halfword drives `dev_wdata` = {16'h0, wdata[7:0], wdata[15:8]}. A word drives all four bytes in reverse order. A byte write to a register drives {24'h0, wdata[7:0]}.
- R6: Read results are formatted by target. A register byte read returns {24'h0, dev_rdata[7:0]}. A halfword data read returns {16'h0, dev_rdata[7:0], dev_rdata[15:8]}. A word data read returns dev_rdata with its bytes reversed.
- R7: A read at a slot with no register returns 32'h000000FF for a byte, 32'h0000FFFF for a halfword, and 32'hFFFFFFFF for a word or for the reserved size code 3.
- R8: A write at a slot with no register, a halfword or word write at a non-zero slot, and any write with size code 3 pulse no register-side strobe.
- R9: A byte access at slot 0 has no register and behaves as in R7 and R8.
- R10: `host_rvalid` pulses for one cycle, one cycle after each read strobe. `host_rdata` changes only then and holds its value otherwise. Both are 0 after reset.
- R11: At most one register-side strobe is active in any cycle in which the host does not raise read and write together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 12 | Byte address within the window |
| host_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| host_rd | input | 1 | One-cycle read strobe |
| host_wr | input | 1 | One-cycle write strobe |
| host_wdata | input | 32 | Write data, right-justified |
| host_rdata | output | 32 | Registered read result |
| host_rvalid | output | 1 | Read result valid pulse |
| dev_reg_idx | output | 3 | Command-block register number (1..7), else 0 |
| dev_cb_rd | output | 1 | Command-block register read strobe |
| dev_cb_wr | output | 1 | Command-block register write strobe |
| dev_alt_rd | output | 1 | Alternate-status read strobe |
| dev_ctl_wr | output | 1 | Device-control write strobe |
| dev_dat_rd | output | 1 | Data-port read strobe |
| dev_dat_wr | output | 1 | Data-port write strobe |
| dev_dat_wide | output | 1 | Data-port access is 32 bits (1) or 16 bits (0) |
| dev_wdata | output | 32 | Write data toward the drive registers |
| dev_rdata | input | 32 | Register read data from the drive, same cycle |

## Verification
The embedded properties watch every cycle for the read-valid timing and the holding of read data. They also check that register strobes are mutually exclusive, that command-block strobes never carry slot number 0, that data-port strobes only come from slot 0, and that no-register byte reads return 0xFF. Only the bench's scenarios can show the full slot map: which slots route where, the aliasing of slots 8 and 22, the exact byte order of swapped data at each width, and the width-dependent all-ones fill. The bench sweeps every slot at every size in both directions to cover these.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;

    localparam int BUS_W = 32;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        TGT_NONE     = 2'd0,
        TGT_TASKFILE = 2'd1,
        TGT_CONTROL  = 2'd2,
        TGT_DATA     = 2'd3
    } target_e;

    typedef struct packed {
        target_e    tgt;
        logic [2:0] reg_idx;
        logic       wide;
    } route_t;

    // All-ones read value for an access that lands on no register.
    function automatic logic [BUS_W-1:0] ones_fill(input acc_size_e sz);
        case (sz)
            ACC_BYTE: ones_fill = 32'h0000_00FF;
            ACC_HALF: ones_fill = 32'h0000_FFFF;
            default:  ones_fill = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/ide_win_decode.sv
module ide_win_decode
    import ide_win_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int STRIDE_LOG2 = 4,
    parameter int CTRL_SLOT_A = 8,
    parameter int CTRL_SLOT_B = 22,
    parameter int TF_FIRST    = 1,
    parameter int TF_LAST     = 7
) (
    input  logic [ADDR_W-1:0] addr,
    input  acc_size_e         size,
    output route_t            route
);
    localparam int SLOT_W = ADDR_W - STRIDE_LOG2;

    logic [SLOT_W-1:0] slot;
    logic [3:0]        low_unused;

    assign slot       = addr[ADDR_W-1:STRIDE_LOG2];
    assign low_unused = addr[STRIDE_LOG2-1:0];

    always_comb begin
        route = '{tgt: TGT_NONE, reg_idx: 3'd0, wide: 1'b0};
        case (size)
            ACC_BYTE: begin
                if (int'(slot) >= TF_FIRST && int'(slot) <= TF_LAST) begin
                    route.tgt     = TGT_TASKFILE;
                    route.reg_idx = slot[2:0];
                end else if (int'(slot) == CTRL_SLOT_A || int'(slot) == CTRL_SLOT_B) begin
                    route.tgt = TGT_CONTROL;
                end
            end
            ACC_HALF, ACC_WORD: begin
                if (slot == '0) begin
                    route.tgt  = TGT_DATA;
                    route.wide = (size == ACC_WORD);
                end
            end
            default: route = '{tgt: TGT_NONE, reg_idx: 3'd0, wide: 1'b0};
        endcase
    end

    // Offset within a slot never influences routing.
    logic unused_ok;
    assign unused_ok = ^low_unused;

endmodule

// File: rtl/ide_win_swap.sv
module ide_win_swap #(
    parameter int BYTES = 4
) (
    input  logic [BYTES*8-1:0] din,
    output logic [BYTES*8-1:0] dout
);
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign dout[b*8 +: 8] = din[(BYTES-1-b)*8 +: 8];
    end
endmodule

// File: rtl/ide_win_rdret.sv
module ide_win_rdret
    import ide_win_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rd,
    input  logic [BUS_W-1:0] fmt_data,
    output logic [BUS_W-1:0] rdata,
    output logic             rvalid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd;
            if (rd) rdata <= fmt_data;
        end
    end

    a_r10_valid_follows_read: assert property (@(posedge clk) disable iff (rst)
        rd |=> rvalid);
    a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !rd |=> !rvalid);
    a_r10_data_holds: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata));
endmodule

// File: rtl/ide_win_bridge.sv
module ide_win_bridge
    import ide_win_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int STRIDE_LOG2 = 4,
    parameter int CTRL_SLOT_A = 8,
    parameter int CTRL_SLOT_B = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [1:0]        host_size,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              host_rvalid,
    output logic [2:0]        dev_reg_idx,
    output logic              dev_cb_rd,
    output logic              dev_cb_wr,
    output logic              dev_alt_rd,
    output logic              dev_ctl_wr,
    output logic              dev_dat_rd,
    output logic              dev_dat_wr,
    output logic              dev_dat_wide,
    output logic [31:0]       dev_wdata,
    input  logic [31:0]       dev_rdata
);
    localparam int SLOT_W = ADDR_W - STRIDE_LOG2;

    acc_size_e size_e;
    route_t    route;

    assign size_e = acc_size_e'(host_size);

    ide_win_decode #(
        .ADDR_W(ADDR_W), .STRIDE_LOG2(STRIDE_LOG2),
        .CTRL_SLOT_A(CTRL_SLOT_A), .CTRL_SLOT_B(CTRL_SLOT_B),
        .TF_FIRST(1), .TF_LAST(7)
    ) u_dec (
        .addr(host_addr), .size(size_e), .route(route)
    );

    // Byte reversal at both widths, both directions.
    logic [15:0] wr_sw16, rd_sw16;
    logic [31:0] wr_sw32, rd_sw32;

    ide_win_swap #(.BYTES(2)) u_wr16 (.din(host_wdata[15:0]), .dout(wr_sw16));
    ide_win_swap #(.BYTES(4)) u_wr32 (.din(host_wdata),       .dout(wr_sw32));
    ide_win_swap #(.BYTES(2)) u_rd16 (.din(dev_rdata[15:0]),  .dout(rd_sw16));
    ide_win_swap #(.BYTES(4)) u_rd32 (.din(dev_rdata),        .dout(rd_sw32));

    // Register-side strobes, same cycle as the host strobe.
    assign dev_cb_rd    = host_rd && (route.tgt == TGT_TASKFILE);
    assign dev_cb_wr    = host_wr && (route.tgt == TGT_TASKFILE);
    assign dev_alt_rd   = host_rd && (route.tgt == TGT_CONTROL);
    assign dev_ctl_wr   = host_wr && (route.tgt == TGT_CONTROL);
    assign dev_dat_rd   = host_rd && (route.tgt == TGT_DATA);
    assign dev_dat_wr   = host_wr && (route.tgt == TGT_DATA);
    assign dev_dat_wide = route.wide;
    assign dev_reg_idx  = route.reg_idx;

    always_comb begin
        if (route.tgt == TGT_DATA)
            dev_wdata = route.wide ? wr_sw32 : {16'h0, wr_sw16};
        else
            dev_wdata = {24'h0, host_wdata[7:0]};
    end

    logic [31:0] rd_fmt;
    always_comb begin
        case (route.tgt)
            TGT_NONE:     rd_fmt = ones_fill(size_e);
            TGT_DATA:     rd_fmt = route.wide ? rd_sw32 : {16'h0, rd_sw16};
            default:      rd_fmt = {24'h0, dev_rdata[7:0]};
        endcase
    end

    ide_win_rdret u_ret (
        .clk(clk), .rst(rst), .rd(host_rd), .fmt_data(rd_fmt),
        .rdata(host_rdata), .rvalid(host_rvalid)
    );

    logic [SLOT_W-1:0] host_slot;
    assign host_slot = host_addr[ADDR_W-1:STRIDE_LOG2];

    a_r11_single_strobe: assert property (@(posedge clk) disable iff (rst)
        !(host_rd && host_wr) |->
            $onehot0({dev_cb_rd, dev_cb_wr, dev_alt_rd, dev_ctl_wr, dev_dat_rd, dev_dat_wr}));
    a_r2_cb_idx_nonzero: assert property (@(posedge clk) disable iff (rst)
        (dev_cb_rd || dev_cb_wr) |-> (dev_reg_idx != 3'd0));
    a_r4_data_at_slot0: assert property (@(posedge clk) disable iff (rst)
        (dev_dat_rd || dev_dat_wr) |-> (host_slot == '0));
    a_r8_rsvd_write_silent: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_size == 2'd3) |-> !(dev_cb_wr || dev_ctl_wr || dev_dat_wr));
    a_r7_unmapped_byte_read: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_size == 2'd0 && !dev_cb_rd && !dev_alt_rd) |=>
            (host_rdata == 32'h0000_00FF));
endmodule

// File: tb/tb_ide_win_bridge.sv
module tb_ide_win_bridge;
    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] host_addr;
    logic [1:0]  host_size;
    logic        host_rd, host_wr;
    logic [31:0] host_wdata, host_rdata, dev_wdata, dev_rdata;
    logic        host_rvalid;
    logic [2:0]  dev_reg_idx;
    logic        dev_cb_rd, dev_cb_wr, dev_alt_rd, dev_ctl_wr, dev_dat_rd, dev_dat_wr, dev_dat_wide;

    int errors = 0;
    int checks = 0;
    logic [31:0] last_rd;

    always #10 clk = ~clk;

    ide_win_bridge dut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_size(host_size),
        .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .dev_reg_idx(dev_reg_idx), .dev_cb_rd(dev_cb_rd), .dev_cb_wr(dev_cb_wr),
        .dev_alt_rd(dev_alt_rd), .dev_ctl_wr(dev_ctl_wr), .dev_dat_rd(dev_dat_rd),
        .dev_dat_wr(dev_dat_wr), .dev_dat_wide(dev_dat_wide),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // strobe vector order: {cb_wr, cb_rd, ctl_wr, alt_rd, dat_wr, dat_rd}
    task automatic access(input int sz, input int slot, input bit is_wr);
        logic [7:0]  s8;
        logic [5:0]  exp_sb, act_sb;
        logic [31:0] exp_w, exp_r;
        string       tag;
        bit          tf, ctl, dat;
        s8  = slot[7:0];
        tf  = (sz == 0) && slot >= 1 && slot <= 7;
        ctl = (sz == 0) && (slot == 8 || slot == 22);
        dat = (sz == 1 || sz == 2) && slot == 0;
        if (tf) tag = "R2"; else if (ctl) tag = "R3"; else if (dat) tag = "R4";
        else if (sz == 0 && slot == 0) tag = "R9"; else tag = is_wr ? "R8" : "R7";
        exp_sb = {is_wr && tf, !is_wr && tf, is_wr && ctl, !is_wr && ctl, is_wr && dat, !is_wr && dat};

        host_addr  = {s8, s8[3:0] ^ 4'(sz * 5)};   // R1: varying low nibble
        host_size  = sz[1:0];
        host_wdata = {s8, s8 ^ 8'h5A, 8'hA5 + 8'(sz), s8 ^ 8'h3C};
        dev_rdata  = {s8, ~s8, s8 + 8'h11, s8 ^ 8'h77};
        host_rd    = !is_wr;
        host_wr    = is_wr;
        #2;
        act_sb = {dev_cb_wr, dev_cb_rd, dev_ctl_wr, dev_alt_rd, dev_dat_wr, dev_dat_rd};
        check(act_sb == exp_sb, {tag, "/R1/R11 strobes"}, {26'h0, act_sb}, {26'h0, exp_sb});
        if (tf) check(dev_reg_idx == slot[2:0], "R2 reg idx", {29'h0, dev_reg_idx}, slot);
        if (dat) check(dev_dat_wide == (sz == 2), "R4 wide", {31'h0, dev_dat_wide}, {31'h0, sz == 2});
        if (is_wr && (tf || ctl || dat)) begin
            if (sz == 2)      exp_w = {host_wdata[7:0], host_wdata[15:8], host_wdata[23:16], host_wdata[31:24]};
            else if (sz == 1) exp_w = {16'h0, host_wdata[7:0], host_wdata[15:8]};
            else              exp_w = {24'h0, host_wdata[7:0]};
            check(dev_wdata == exp_w, "R5 write data", dev_wdata, exp_w);
        end
        if (!is_wr) begin
            if (tf || ctl)    exp_r = {24'h0, dev_rdata[7:0]};
            else if (dat && sz == 2) exp_r = {dev_rdata[7:0], dev_rdata[15:8], dev_rdata[23:16], dev_rdata[31:24]};
            else if (dat)     exp_r = {16'h0, dev_rdata[7:0], dev_rdata[15:8]};
            else if (sz == 0) exp_r = 32'h0000_00FF;
            else if (sz == 1) exp_r = 32'h0000_FFFF;
            else              exp_r = 32'hFFFF_FFFF;
        end else exp_r = last_rd;
        @(negedge clk);
        host_rd = 1'b0;
        host_wr = 1'b0;
        #2;
        check(host_rvalid == !is_wr, "R10 rvalid", {31'h0, host_rvalid}, {31'h0, !is_wr});
        check(host_rdata == exp_r, is_wr ? "R10 rdata hold" : {tag, "/R6 read data"}, host_rdata, exp_r);
        last_rd = exp_r;
    endtask

    initial begin
        rst = 1'b1; host_addr = '0; host_size = '0; host_rd = 1'b0; host_wr = 1'b0;
        host_wdata = '0; dev_rdata = '0; last_rd = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        check(host_rdata == 32'h0 && !host_rvalid, "R10 reset state", host_rdata, 32'h0);
        for (int sz = 0; sz < 4; sz++)
            for (int slot = 0; slot < 256; slot++) begin
                access(sz, slot, 1'b1);
                access(sz, slot, 1'b0);
            end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired act=%0d exp=done", checks);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule